// File: doc/BRIEF.md
# Masked Five-Bit Chi S-box Without Share Compression

This block evaluates the five-bit nonlinear substitution layer of a lightweight sponge permutation on Boolean-masked data, entirely in combinational logic. Every input bit arrives as `NSHARE` shares whose XOR is the bit's value. Three of the inputs (b, d, e) also arrive a second time as separate signals. These copies hold the same values as the originals but use their own, independently drawn masks. The copies are wired into those AND gates whose two operands would otherwise come from the same source variable. As a result, no gate ever joins two shares of one variable.

The block does not recombine the product terms after the AND layer. Each output bit therefore leaves as `NSHARE*NSHARE` shares, indexed by a pair (i, j). Each output share is built from at most one share index of every input variable. The block holds no registers and consumes no fresh random bits. A downstream stage is expected to remask and compress the shares once a register boundary is acceptable.

Top module: `chi5_masked_sbox`

## Requirements
- R1: When each duplicate input holds the same unmasked value as its original, the XOR of all shares of each output equals the unmasked function, with x = a^e, y = b^c, z = d^e:
  - out_a = x ^ z ^ (~b & y) ^ (~x & b)
  - out_b = b ^ ~y&d ^ x ^ (~b & y)
  - out_c = ~(y ^ (~d & z))
  - out_d = d ^ ~z&(a^e) ^ y ^ (~d & z)
  - out_e = z ^ (~x & b)
- R2: Input share k sits at bit k of each input vector. Output share (i, j) sits at bit i*NSHARE+j of each output vector.
- R3: A diagonal output share (i, i) depends only on index-i shares of the inputs.
- R4: In an off-diagonal share (i, j), out_a uses a, e and the b duplicate at index i, and b and c at index j. In the same share, out_e uses a and e at index i and b at index j.
- R5: In an off-diagonal share (i, j), out_b uses b and c at index i, and d and the b duplicate at index j. In the same share, out_d uses d and e at index i, and a, the d duplicate and the e duplicate at index j.
- R6: In an off-diagonal share (i, j), out_c uses the d duplicate at index i, and d and e at index j.
- R7: Logical inversions act only on share 0. With every input share at 0, share (0,0) of out_c is 1 and every other output share is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_sh | input | NSHARE | shares of input a |
| b_sh | input | NSHARE | shares of input b |
| c_sh | input | NSHARE | shares of input c |
| d_sh | input | NSHARE | shares of input d |
| e_sh | input | NSHARE | shares of input e |
| b_dup_sh | input | NSHARE | independently masked copy of b |
| d_dup_sh | input | NSHARE | independently masked copy of d |
| e_dup_sh | input | NSHARE | independently masked copy of e |
| a_out_sh | output | NSHARE*NSHARE | uncompressed shares of out_a |
| b_out_sh | output | NSHARE*NSHARE | uncompressed shares of out_b |
| c_out_sh | output | NSHARE*NSHARE | uncompressed shares of out_c |
| d_out_sh | output | NSHARE*NSHARE | uncompressed shares of out_d |
| e_out_sh | output | NSHARE*NSHARE | uncompressed shares of out_e |

## Verification
The correctness assertions take for granted that each duplicate input unmasks to the same bit as its original. They are gated on that condition, because the block cannot give a meaningful result otherwise. The stimulus always draws the duplicate's share 0 independently of the original's share 0, and sets share 1 so that both unmask to the intended value. The only time this equality is broken on purpose is during the single-share flip probes, and the assertions stay quiet there.

// File: rtl/chi5_mask_pkg.sv
// Shared types and the unmasked reference used by the masked S-box.
// Assumes bit 0 of a result vector is out_a and bit 4 is out_e.
package chi5_mask_pkg;

    localparam int CHI_BITS = 5;

    // Linear pre-terms of one share domain, with share-0 inversion applied.
    typedef struct packed {
        logic b;
        logic d;
        logic ae;
        logic bc;
        logic de;
        logic aep;
        logic n_bp;
        logic n_dp;
        logic n_ae;
        logic n_bc;
        logic n_de;
    } share_prep_t;

    // Unmasked S-box, used only by the assertions of the top module.
    function automatic logic [CHI_BITS-1:0] chi5_plain(
        input logic a, input logic b, input logic c,
        input logic d, input logic e
    );
        logic [CHI_BITS-1:0] r;
        r[0] = (a ^ e) ^ (~b & (b ^ c)) ^ (d ^ e) ^ (~(a ^ e) & b);
        r[1] = b ^ (~(b ^ c) & d) ^ (a ^ e) ^ (~b & (b ^ c));
        r[2] = ~((b ^ c) ^ (~d & (d ^ e)));
        r[3] = d ^ (~(d ^ e) & (a ^ e)) ^ (b ^ c) ^ (~d & (d ^ e));
        r[4] = (d ^ e) ^ (~(a ^ e) & b);
        return r;
    endfunction

endpackage

// File: rtl/chi5_share_prep.sv
// Per-domain linear preparation: XOR pre-terms and inverted operands.
// Assumes share 0 of every value carries the logical inversion; the
// other shares pass through unchanged so the sharing stays correct.
module chi5_share_prep
    import chi5_mask_pkg::*;
#(
    parameter int NSHARE = 2
) (
    input  logic [NSHARE-1:0] a_sh,
    input  logic [NSHARE-1:0] b_sh,
    input  logic [NSHARE-1:0] c_sh,
    input  logic [NSHARE-1:0] d_sh,
    input  logic [NSHARE-1:0] e_sh,
    input  logic [NSHARE-1:0] bd_sh,
    input  logic [NSHARE-1:0] dd_sh,
    input  logic [NSHARE-1:0] ed_sh,
    output share_prep_t [NSHARE-1:0] prep
);

    for (genvar k = 0; k < NSHARE; k++) begin : g_dom
        localparam logic INV = (k == 0) ? 1'b1 : 1'b0;
        share_prep_t p;

        // Build the linear pre-terms of domain k from index-k shares only.
        always_comb begin
            p.b    = b_sh[k];
            p.d    = d_sh[k];
            p.ae   = a_sh[k] ^ e_sh[k];
            p.bc   = b_sh[k] ^ c_sh[k];
            p.de   = d_sh[k] ^ e_sh[k];
            p.aep  = a_sh[k] ^ ed_sh[k];
            p.n_bp = bd_sh[k] ^ INV;
            p.n_dp = dd_sh[k] ^ INV;
            p.n_ae = a_sh[k] ^ e_sh[k] ^ INV;
            p.n_bc = b_sh[k] ^ c_sh[k] ^ INV;
            p.n_de = d_sh[k] ^ e_sh[k] ^ INV;
        end

        assign prep[k] = p;
    end

endmodule

// File: rtl/chi5_share_term.sv
// One output share (ROW, COL) of all five S-box outputs.
// Diagonal shares hold the linear terms and same-domain products.
// Off-diagonal shares hold only cross products: the first AND operand
// comes from domain ROW and the second from domain COL, mirrored for
// out_b and out_d so no variable meets two share indices.
module chi5_share_term
    import chi5_mask_pkg::*;
#(
    parameter int NSHARE = 2,
    parameter int ROW    = 0,
    parameter int COL    = 0
) (
    input  share_prep_t [NSHARE-1:0] prep,
    output logic [CHI_BITS-1:0]      y
);

    if (ROW == COL) begin : g_diag
        localparam logic INV = (ROW == 0) ? 1'b1 : 1'b0;
        share_prep_t p;
        assign p = prep[ROW];

        // Combine linear terms with products drawn from one domain.
        always_comb begin
            y[0] = p.ae ^ p.de ^ (p.n_bp & p.bc) ^ (p.n_ae & p.b);
            y[1] = p.b ^ (p.n_bc & p.d) ^ p.ae ^ (p.n_bp & p.bc);
            y[2] = p.bc ^ (p.n_dp & p.de) ^ INV;
            y[3] = p.d ^ (p.n_de & p.aep) ^ p.bc ^ (p.n_dp & p.de);
            y[4] = p.de ^ (p.n_ae & p.b);
        end
    end else begin : g_cross
        share_prep_t r;
        share_prep_t c;
        assign r = prep[ROW];
        assign c = prep[COL];

        // Form cross-domain products with fixed index roles per output.
        always_comb begin
            y[0] = (r.n_bp & c.bc) ^ (r.n_ae & c.b);
            y[1] = (r.n_bc & c.d) ^ (c.n_bp & r.bc);
            y[2] = r.n_dp & c.de;
            y[3] = (r.n_de & c.aep) ^ (c.n_dp & r.de);
            y[4] = r.n_ae & c.b;
        end
    end

endmodule

// File: rtl/chi5_masked_sbox.sv
// Combinational masked five-bit chi S-box with uncompressed outputs.
// Assumes each duplicate input unmasks to the same value as its original
// and is masked independently of it. Output share (i,j) sits at bit
// i*NSHARE+j. No registers, no fresh randomness.
module chi5_masked_sbox
    import chi5_mask_pkg::*;
#(
    parameter int NSHARE = 2
) (
    input  logic [NSHARE-1:0]        a_sh,
    input  logic [NSHARE-1:0]        b_sh,
    input  logic [NSHARE-1:0]        c_sh,
    input  logic [NSHARE-1:0]        d_sh,
    input  logic [NSHARE-1:0]        e_sh,
    input  logic [NSHARE-1:0]        b_dup_sh,
    input  logic [NSHARE-1:0]        d_dup_sh,
    input  logic [NSHARE-1:0]        e_dup_sh,
    output logic [NSHARE*NSHARE-1:0] a_out_sh,
    output logic [NSHARE*NSHARE-1:0] b_out_sh,
    output logic [NSHARE*NSHARE-1:0] c_out_sh,
    output logic [NSHARE*NSHARE-1:0] d_out_sh,
    output logic [NSHARE*NSHARE-1:0] e_out_sh
);

    localparam int NOUT = NSHARE * NSHARE;

    share_prep_t [NSHARE-1:0] prep;
    logic [CHI_BITS-1:0]      share_y [NOUT];

    chi5_share_prep #(.NSHARE(NSHARE)) u_prep (
        .a_sh  (a_sh),
        .b_sh  (b_sh),
        .c_sh  (c_sh),
        .d_sh  (d_sh),
        .e_sh  (e_sh),
        .bd_sh (b_dup_sh),
        .dd_sh (d_dup_sh),
        .ed_sh (e_dup_sh),
        .prep  (prep)
    );

    for (genvar i = 0; i < NSHARE; i++) begin : g_row
        for (genvar j = 0; j < NSHARE; j++) begin : g_col
            chi5_share_term #(.NSHARE(NSHARE), .ROW(i), .COL(j)) u_term (
                .prep (prep),
                .y    (share_y[i*NSHARE+j])
            );
        end
    end

    // Scatter per-share result vectors onto the five output buses.
    always_comb begin
        for (int s = 0; s < NOUT; s++) begin
            a_out_sh[s] = share_y[s][0];
            b_out_sh[s] = share_y[s][1];
            c_out_sh[s] = share_y[s][2];
            d_out_sh[s] = share_y[s][3];
            e_out_sh[s] = share_y[s][4];
        end
    end

    // Check recombined outputs against the unmasked function (R1, R7).
    logic                dup_ok;
    logic                all_zero;
    logic [CHI_BITS-1:0] plain_ref;

    always_comb begin
        dup_ok    = ((^b_sh) == (^b_dup_sh)) && ((^d_sh) == (^d_dup_sh))
                 && ((^e_sh) == (^e_dup_sh));
        all_zero  = ~|{a_sh, b_sh, c_sh, d_sh, e_sh, b_dup_sh, d_dup_sh, e_dup_sh};
        plain_ref = chi5_plain(^a_sh, ^b_sh, ^c_sh, ^d_sh, ^e_sh);
        if (dup_ok) begin
            p_xor_a_r1: assert ((^a_out_sh) == plain_ref[0]) else $error("out_a recombination wrong");
            p_xor_b_r1: assert ((^b_out_sh) == plain_ref[1]) else $error("out_b recombination wrong");
            p_xor_c_r1: assert ((^c_out_sh) == plain_ref[2]) else $error("out_c recombination wrong");
            p_xor_d_r1: assert ((^d_out_sh) == plain_ref[3]) else $error("out_d recombination wrong");
            p_xor_e_r1: assert ((^e_out_sh) == plain_ref[4]) else $error("out_e recombination wrong");
        end
        if (all_zero) begin
            p_zero_inv_r7: assert (c_out_sh == NOUT'(1) && ~|{a_out_sh, b_out_sh, d_out_sh, e_out_sh})
                else $error("inversion not confined to share 0");
        end
    end

endmodule

// File: tb/chi5_masked_sbox_test.sv
// Bench: random sharings of all 32 values, directed zero sharing, and
// single-share flip probes that check which share indices feed each output.
module chi5_masked_sbox_test;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // Variable order: 0 a, 1 b, 2 c, 3 d, 4 e, 5 b dup, 6 d dup, 7 e dup.
    logic [1:0] sh [8];
    logic [3:0] yo [5];
    logic [3:0] base [5];

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    chi5_masked_sbox #(.NSHARE(2)) uut (
        .a_sh(sh[0]), .b_sh(sh[1]), .c_sh(sh[2]), .d_sh(sh[3]), .e_sh(sh[4]),
        .b_dup_sh(sh[5]), .d_dup_sh(sh[6]), .e_dup_sh(sh[7]),
        .a_out_sh(yo[0]), .b_out_sh(yo[1]), .c_out_sh(yo[2]),
        .d_out_sh(yo[3]), .e_out_sh(yo[4])
    );

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WD_LIMIT) begin
            fails  = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: act=%0d cycles exp<%0d", cyc, WD_LIMIT);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    // Unmasked reference; x[0]=a .. x[4]=e, result bit 0 = out_a.
    function automatic logic [4:0] ref_sbox(input logic [4:0] x);
        logic a, b, c, d, e, t1, t2, t3;
        logic [4:0] r;
        a = x[0]; b = x[1]; c = x[2]; d = x[3]; e = x[4];
        t1 = a ^ e; t2 = b ^ c; t3 = d ^ e;
        r[4] = t3 ^ (~t1 & b);
        r[0] = t1 ^ t3 ^ (~b & t2) ^ (~t1 & b);
        r[2] = ~(t2 ^ (~d & t3));
        r[1] = b ^ t1 ^ (~t2 & d) ^ (~b & t2);
        r[3] = d ^ t2 ^ (~t3 & t1) ^ (~d & t3);
        return r;
    endfunction

    // Index of variable v expected in output o share (i,j); -1 if unused.
    function automatic int idx_use(input int o, input int v, input int i, input int j);
        if (i == j) return i;
        case (o)
            0: case (v) 0, 4, 5: return i; 1, 2: return j; default: return -1; endcase
            1: case (v) 1, 2: return i; 3, 5: return j; default: return -1; endcase
            2: case (v) 6: return i; 3, 4: return j; default: return -1; endcase
            3: case (v) 3, 4: return i; 0, 6, 7: return j; default: return -1; endcase
            default: case (v) 0, 4: return i; 1: return j; default: return -1; endcase
        endcase
    endfunction

    function automatic string req_of(input int o, input int i, input int j);
        if (i == j) return "R3";
        if (o == 1 || o == 3) return "R5";
        if (o == 2) return "R6";
        return "R4";
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    // Drive a fresh random sharing of value x, duplicates masked independently.
    task automatic drive_value(input logic [4:0] x);
        logic [4:0] m;
        logic [2:0] md;
        @(negedge clk);
        m  = 5'($urandom);
        md = 3'($urandom);
        for (int v = 0; v < 5; v++) sh[v] = {x[v] ^ m[v], m[v]};
        sh[5] = {x[1] ^ md[0], md[0]};
        sh[6] = {x[3] ^ md[1], md[1]};
        sh[7] = {x[4] ^ md[2], md[2]};
        #(CLK_PERIOD/4);
    endtask

    initial begin
        int unsigned seed_init;
        logic [4:0] exp_v;
        seed_init = $urandom(32'd5071);
        for (int v = 0; v < 8; v++) sh[v] = 2'b00;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R7 and R2: all-zero shares, inversion lands only in share (0,0).
        @(negedge clk);
        #(CLK_PERIOD/4);
        check("R7", "c shares at zero input", int'(yo[2]), 1);
        check("R2", "other shares at zero input", int'({yo[0], yo[1], yo[3], yo[4]}), 0);

        // R1: every unmasked value under several random sharings.
        for (int rep = 0; rep < 8; rep++) begin
            for (int x = 0; x < 32; x++) begin
                drive_value(5'(x));
                exp_v = ref_sbox(5'(x));
                for (int o = 0; o < 5; o++)
                    check("R1", $sformatf("x=%0d out%0d", x, o), int'(^yo[o]), int'(exp_v[o]));
            end
        end

        // R3..R6: flip one input share; shares not using it must hold.
        for (int rep = 0; rep < 48; rep++) begin
            drive_value(5'($urandom));
            for (int o = 0; o < 5; o++) base[o] = yo[o];
            for (int v = 0; v < 8; v++) begin
                for (int k = 0; k < 2; k++) begin
                    @(negedge clk);
                    sh[v][k] = ~sh[v][k];
                    #(CLK_PERIOD/4);
                    for (int o = 0; o < 5; o++)
                        for (int i = 0; i < 2; i++)
                            for (int j = 0; j < 2; j++)
                                if (idx_use(o, v, i, j) != k)
                                    check(req_of(o, i, j),
                                          $sformatf("out%0d share(%0d,%0d) var%0d idx%0d", o, i, j, v, k),
                                          int'(yo[o][i*2+j]), int'(base[o][i*2+j]));
                    @(negedge clk);
                    sh[v][k] = ~sh[v][k];
                    #(CLK_PERIOD/4);
                end
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule